// File: doc/BRIEF.md
# Transform Block Ordering Sequencer

This block sits ahead of a block-based transform engine and decides which input blocks the engine works on and in what order the results come out. The two sample lanes, real and imaginary, report each finished block with a one-cycle completion strobe. A 3-bit mode code says whether the lanes carry one source or two independent sources, and how far successive transform windows overlap. From that the block produces a stream of descriptors over a valid/ready handshake. Each descriptor names a lane tag, a block index and a window offset given in eighths of a block.

Descriptors go out in groups. A group starts once `GROUP` blocks, or `GROUP` lane pairs, have completed. Inside a group the window offset is the outermost loop, the pair number comes next and the lane is the innermost loop. The result is the lane-interleaved, offset-repeated ordering that overlapped and dual-source processing needs. The transform arithmetic and the sample storage are outside this block.

Top module: `fft_order_seq`

## Requirements
- R1: After reset, `desc_valid` is low, the active mode code is 000, no completions are pending, and the block index counter starts at 0.
- R2: In mode 000, each group holds `GROUP` real-lane completions. It yields one descriptor per block, with tag 0, offset 0 and consecutive indices. Imaginary-lane strobes are not counted and produce nothing.
- R3: In modes 101, 110 and 111, lane pair n carries block n of source A (real lane, tag 0) and block n of source B (imaginary lane, tag 1). Both carry the same index n.
- R4: Within each pair, the descriptor with tag 0 is always issued directly before the descriptor with tag 1.
- R5: The offset step in eighths of a block is 6 for code 001, 4 for 010, 2 for 011, 1 for 100, 4 for 110 and 2 for 111. Codes 000 and 101 have no overlap. A group repeats its descriptors at offsets 0, step, 2*step and so on, for every value below 8.
- R6: In modes 001 to 100, the single source is split across the lanes. In pair n the real lane holds block 2n and the imaginary lane holds block 2n+1, so the indices run 0,1 then 0,1 shifted, then 2,3 and so on.
- R7: A group starts only once every lane in use has at least `GROUP` pending completions. It emits in the order offset (outer), pair (middle), lane (inner). Afterwards the index base advances by `GROUP` pairs.
- R8: While `desc_valid` is high and `desc_ready` is low, the descriptor fields hold their values and `desc_valid` stays high.
- R9: A mode write is held as pending and applied only while no group is being emitted. A later write replaces an earlier pending one. Applying a mode clears the pending completions and restarts the index base at 0.
- R10: Completions that arrive while a group is being emitted are counted and served by a later group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_code | input | 3 | Mode code to write |
| re_blk_done | input | 1 | Real-lane block complete strobe |
| im_blk_done | input | 1 | Imaginary-lane block complete strobe |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Engine accepts descriptor |
| desc_src | output | 1 | Lane tag: 0 real/source A, 1 imaginary/source B |
| desc_idx | output | IDXW | Block index |
| desc_ofs | output | 3 | Window offset in eighths of a block |

## Verification
The bench runs a group in all eight modes, so a wrong entry in the step table shows up as missing or extra shifted descriptors. A single-source mode that indexes per source would show up as index pairs n,n where n,n+1 is expected. Mode changes are written while a long group is still being emitted. A design that switched mode mid-group, or that kept stale completions or an old index base, would break the ordering the scoreboard expects. The bench also sends imaginary strobes in mode 000, strobes in the middle of emission, and back-pressure. These catch, in turn, a design that counts ignored strobes, one that drops completions, and one that changes a stalled descriptor.

// File: rtl/ordseq_pkg.sv
// Shared types and mode decoding for the ordering sequencer.
// Assumes offsets are measured in eighths of a block.
package ordseq_pkg;

    localparam int OFS_W   = 3;
    localparam int EIGHTHS = 8;

    typedef struct packed {
        logic       two_lanes;  // imaginary lane carries data
        logic       split_idx;  // one source split across lanes: idx 2n / 2n+1
        logic [3:0] hop;        // offset step in eighths, 8 = no overlap
    } mode_cfg_t;

    // Translate a 3-bit mode code into lane usage and overlap step.
    function automatic mode_cfg_t decode_mode(input logic [2:0] code);
        mode_cfg_t c;
        c.two_lanes = (code != 3'b000);
        c.split_idx = (code >= 3'b001) && (code <= 3'b100);
        case (code)
            3'b001:  c.hop = 4'd6;
            3'b010:  c.hop = 4'd4;
            3'b011:  c.hop = 4'd2;
            3'b100:  c.hop = 4'd1;
            3'b110:  c.hop = 4'd4;
            3'b111:  c.hop = 4'd2;
            default: c.hop = 4'd8;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ordseq_mode_reg.sv
// Mode register with deferred apply.
// A write is parked as pending and copied to the active code only while the
// emitter reports idle. The apply pulse lets the other units restart.
module ordseq_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_code,
    input  logic       idle,
    output logic [2:0] act_code,
    output logic       pend_valid,
    output logic       apply
);

    logic [2:0] pend_code;

    // Hold the latest write and move it to the active code when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code   <= 3'b000;
            pend_code  <= 3'b000;
            pend_valid <= 1'b0;
            apply      <= 1'b0;
        end else begin
            apply <= 1'b0;
            if (wr_en) begin
                pend_code  <= wr_code;
                pend_valid <= 1'b1;
            end else if (pend_valid && idle) begin
                act_code   <= pend_code;
                pend_valid <= 1'b0;
                apply      <= 1'b1;
            end
        end
    end

    AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(act_code)); // R9

endmodule

// File: rtl/ordseq_lane_count.sv
// Pending-completion counter for one input lane.
// Counts strobes while enabled, gives back GROUP on consume, and is flushed
// by clear. Assumes the environment never exceeds PEND_MAX pending blocks.
module ordseq_lane_count #(
    parameter int GROUP    = 1,
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic enable,
    input  logic clear,
    input  logic consume,
    output logic grp_ready
);

    localparam int CW = $clog2(PEND_MAX + 1);
    localparam logic [CW-1:0] GRP_C = CW'(GROUP);
    localparam logic [CW-1:0] MAX_C = CW'(PEND_MAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          inc;

    // Next count from strobe and consume.
    always_comb begin
        inc     = strobe && enable;
        cnt_nxt = cnt + CW'(inc);
        if (consume) cnt_nxt = cnt_nxt - GRP_C;
    end

    // Counter register, flushed on mode apply.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else                 cnt <= cnt_nxt;
    end

    assign grp_ready = (cnt >= GRP_C);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && enable && !clear && !consume) |-> (cnt != MAX_C)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (cnt >= GRP_C)); // R7

endmodule

// File: rtl/ordseq_emit.sv
// Descriptor emitter. Once a group is ready it walks offset (outer),
// pair (middle) and lane (inner), presenting one descriptor at a time on a
// valid/ready handshake. Assumes the mode configuration is steady while busy.
module ordseq_emit
    import ordseq_pkg::*;
#(
    parameter int GROUP = 1,
    parameter int IDXW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_cfg_t        cfg,
    input  logic             hold_off,
    input  logic             clear,
    input  logic             grp_ready,
    output logic             consume,
    output logic             idle,
    output logic             desc_valid,
    input  logic             desc_ready,
    output logic             desc_src,
    output logic [IDXW-1:0]  desc_idx,
    output logic [OFS_W-1:0] desc_ofs
);

    localparam int PW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [PW-1:0] LAST_P = PW'(GROUP - 1);
    localparam logic [IDXW-1:0] GRP_STEP = IDXW'(GROUP);

    logic            busy;
    logic [3:0]      ofs;
    logic [PW-1:0]   pidx;
    logic            lane;
    logic [IDXW-1:0] base;
    logic            fire, last_lane, last_p, last_ofs;
    logic [4:0]      ofs_sum;
    logic [IDXW-1:0] pair_no;

    // Loop-end flags and group start condition.
    always_comb begin
        fire      = busy && desc_ready;
        last_lane = !cfg.two_lanes || lane;
        last_p    = (pidx == LAST_P);
        ofs_sum   = {1'b0, ofs} + {1'b0, cfg.hop};
        last_ofs  = (ofs_sum >= 5'(EIGHTHS));
        consume   = !busy && !hold_off && !clear && grp_ready;
    end

    // Walk the nested loops, one step per accepted descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ofs  <= '0;
            pidx <= '0;
            lane <= 1'b0;
            base <= '0;
        end else if (clear) begin
            base <= '0;
        end else if (consume) begin
            busy <= 1'b1;
            ofs  <= '0;
            pidx <= '0;
            lane <= 1'b0;
        end else if (fire) begin
            if (!last_lane) begin
                lane <= 1'b1;
            end else begin
                lane <= 1'b0;
                if (!last_p) begin
                    pidx <= pidx + 1'b1;
                end else begin
                    pidx <= '0;
                    if (!last_ofs) begin
                        ofs <= ofs_sum[3:0];
                    end else begin
                        busy <= 1'b0;
                        base <= base + GRP_STEP;
                    end
                end
            end
        end
    end

    // Descriptor fields from the loop state.
    always_comb begin
        pair_no    = base + IDXW'(pidx);
        desc_idx   = cfg.split_idx ? {pair_no[IDXW-2:0], lane} : pair_no;
        desc_src   = lane;
        desc_ofs   = ofs[OFS_W-1:0];
        desc_valid = busy;
        idle       = !busy;
    end

    // Tracks whether the last accepted descriptor came from the real lane.
    logic chk_real_seen;
    always_ff @(posedge clk) begin
        if (!rst_n)                chk_real_seen <= 1'b0;
        else if (desc_valid && desc_ready) chk_real_seen <= !desc_src;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_idx)
            && $stable(desc_src) && $stable(desc_ofs))); // R8
    AST_REAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && desc_src) |-> chk_real_seen); // R4
    AST_OFS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ofs < 4'd8)); // R5

endmodule

// File: rtl/fft_order_seq.sv
// Top of the ordering sequencer: mode register, one pending counter per lane
// and the descriptor emitter. Assumes one-cycle completion strobes.
module fft_order_seq
    import ordseq_pkg::*;
#(
    parameter int GROUP    = 1,
    parameter int PEND_MAX = 8,
    parameter int IDXW     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [2:0]       mode_code,
    input  logic             re_blk_done,
    input  logic             im_blk_done,
    output logic             desc_valid,
    input  logic             desc_ready,
    output logic             desc_src,
    output logic [IDXW-1:0]  desc_idx,
    output logic [OFS_W-1:0] desc_ofs
);

    localparam int NLANE = 2;

    logic [2:0]       act_code;
    logic             pend_valid, apply, idle, consume, grp_ready;
    mode_cfg_t        cfg;
    logic [NLANE-1:0] strobe, lane_en, lane_rdy, lane_take;

    ordseq_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(mode_wr), .wr_code(mode_code),
        .idle(idle), .act_code(act_code), .pend_valid(pend_valid), .apply(apply)
    );

    // Lane usage from the active mode; imaginary lane only when two are in use.
    always_comb begin
        cfg       = decode_mode(act_code);
        strobe    = {im_blk_done, re_blk_done};
        lane_en   = {cfg.two_lanes, 1'b1};
        grp_ready = lane_rdy[0] && (lane_rdy[1] || !cfg.two_lanes);
        lane_take = {consume && cfg.two_lanes, consume};
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        ordseq_lane_count #(.GROUP(GROUP), .PEND_MAX(PEND_MAX)) u_cnt (
            .clk(clk), .rst_n(rst_n), .strobe(strobe[g]), .enable(lane_en[g]),
            .clear(apply), .consume(lane_take[g]), .grp_ready(lane_rdy[g])
        );
    end

    ordseq_emit #(.GROUP(GROUP), .IDXW(IDXW)) u_emit (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .hold_off(pend_valid),
        .clear(apply), .grp_ready(grp_ready), .consume(consume), .idle(idle),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_src(desc_src),
        .desc_idx(desc_idx), .desc_ofs(desc_ofs)
    );

endmodule

// File: tb/tb_fft_order_seq.sv
// Scoreboard bench: driver tasks queue the expected descriptors, a monitor
// pops and compares each accepted descriptor.
module tb_fft_order_seq;

    localparam int CLK_PERIOD = 10;
    localparam int GRP  = 2;
    localparam int IDXW = 8;

    typedef struct packed {
        logic            src;
        logic [IDXW-1:0] idx;
        logic [2:0]      ofs;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, mode_wr = 1'b0;
    logic [2:0] mode_code = 3'b000;
    logic re_blk_done = 1'b0, im_blk_done = 1'b0, desc_ready = 1'b0;
    logic desc_valid, desc_src;
    logic [IDXW-1:0] desc_idx;
    logic [2:0] desc_ofs;

    int checks = 0, errors = 0, base = 0;
    bit en_ready = 1'b0;
    exp_t q[$];

    fft_order_seq #(.GROUP(GRP), .PEND_MAX(8), .IDXW(IDXW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
        .re_blk_done(re_blk_done), .im_blk_done(im_blk_done),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_src(desc_src),
        .desc_idx(desc_idx), .desc_ofs(desc_ofs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ready pattern: low one cycle in three, changed just after the edge.
    initial begin
        int n = 0;
        forever begin
            @(posedge clk); #1;
            n++;
            desc_ready = en_ready && ((n % 3) != 0);
        end
    end

    // Monitor: compare accepted descriptors, and check stall stability (R8).
    initial begin
        bit   stalled = 1'b0;
        exp_t held = '0;
        exp_t got, e;
        forever begin
            @(negedge clk);
            got = '{src: desc_src, idx: desc_idx, ofs: desc_ofs};
            if (rst_n && stalled) begin
                checks++;
                if (!desc_valid || got != held) begin
                    errors++;
                    $display("FAIL R8 stalled descriptor changed: got v=%0b %p exp v=1 %p",
                             desc_valid, got, held);
                end
            end
            stalled = rst_n && desc_valid && !desc_ready;
            held    = got;
            if (rst_n && desc_valid && desc_ready) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R2/R3/R7 unexpected descriptor: got %p exp none", got);
                end else begin
                    e = q.pop_front();
                    if (got != e) begin
                        errors++;
                        $display("FAIL R3/R4/R5/R6 order: got src=%0d idx=%0d ofs=%0d exp src=%0d idx=%0d ofs=%0d",
                                 got.src, got.idx, got.ofs, e.src, e.idx, e.ofs);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got hang exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Queue the expected descriptors of one group (R5, R6, R7).
    task automatic expect_group(input logic [2:0] code);
        int hop, nl;
        bit split;
        case (code)
            3'b001: hop = 6;
            3'b010: hop = 4;
            3'b011: hop = 2;
            3'b100: hop = 1;
            3'b110: hop = 4;
            3'b111: hop = 2;
            default: hop = 8;
        endcase
        nl    = (code == 3'b000) ? 1 : 2;
        split = (code >= 3'b001) && (code <= 3'b100);
        for (int o = 0; o < 8; o += hop)
            for (int p = 0; p < GRP; p++)
                for (int l = 0; l < nl; l++)
                    q.push_back('{src: l[0],
                                  idx: split ? IDXW'(2*(base+p)+l) : IDXW'(base+p),
                                  ofs: o[2:0]});
        base += GRP;
    endtask

    task automatic pulse(input bit re, input bit im);
        @(negedge clk); re_blk_done = re; im_blk_done = im;
        @(negedge clk); re_blk_done = 0;  im_blk_done = 0;
    endtask

    task automatic write_mode(input logic [2:0] code);
        @(negedge clk); mode_wr = 1'b1; mode_code = code;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    // Wait for the scoreboard to empty; flag a stuck or lost group.
    task automatic drain(input string tag);
        int t = 0;
        while ((q.size() != 0 || desc_valid) && t < 3000) begin
            @(negedge clk); t++;
        end
        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0 || desc_valid) begin
            errors++;
            $display("FAIL %s: got %0d outstanding exp 0", tag, q.size());
        end
    endtask

    task automatic run_group(input logic [2:0] code);
        expect_group(code);
        for (int p = 0; p < GRP; p++) pulse(1'b1, code != 3'b000);
        drain("R7 group completion");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R1
        if (desc_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset valid: got %0b exp 0", desc_valid);
        end
        rst_n = 1'b1;
        en_ready = 1'b1;
        repeat (2) @(negedge clk);

        // R2: imaginary strobes ignored in mode 000.
        for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        checks++;
        if (desc_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 imag strobe produced output: got %0b exp 0", desc_valid);
        end
        run_group(3'b000); // R1 index starts at 0, R2
        run_group(3'b000);

        // R3/R4 dual source, then every overlap code (R5, R6).
        for (int c = 1; c < 8; c++) begin
            write_mode(c[2:0]);
            repeat (3) @(negedge clk);
            base = 0; // R9 index restart
            run_group(c[2:0]);
            run_group(c[2:0]);
        end

        // R10: completions during emission are kept for the next group.
        write_mode(3'b100);
        repeat (3) @(negedge clk);
        base = 0;
        expect_group(3'b100);
        for (int p = 0; p < GRP; p++) pulse(1'b1, 1'b1);
        wait (desc_valid);
        expect_group(3'b100);
        for (int p = 0; p < GRP; p++) pulse(1'b1, 1'b1);
        drain("R10 strobes during emission");

        // R9: writes during a group take effect afterwards; last write wins.
        write_mode(3'b011);
        repeat (3) @(negedge clk);
        base = 0;
        expect_group(3'b011);
        for (int p = 0; p < GRP; p++) pulse(1'b1, 1'b1);
        wait (desc_valid);
        write_mode(3'b110);
        write_mode(3'b101);
        drain("R9 old mode kept to group end");
        base = 0;
        run_group(3'b101);

        // R9: a mode apply discards a half-collected group.
        pulse(1'b1, 1'b1);
        write_mode(3'b111);
        repeat (3) @(negedge clk);
        base = 0;
        run_group(3'b111);

        en_ready = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule